// File: doc/BRIEF.md
# External interrupt trigger detector

This block sits in front of an interrupt controller and turns eight external interrupt pins into per-pin request-set strobes. Each pin is first brought into the clock domain by two flip-flops. It is then tested against a trigger condition chosen for that pin. There are four conditions: level low, level high, rising edge and falling edge. The block only raises set strobes. Holding, clearing and prioritising the requests is left to the controller.

The trigger condition of each pin is a 2-bit field. The fields are packed four to a byte in two configuration bytes. Software writes and reads these bytes through a small synchronous register port. The write takes effect on the clock edge, and the read data follows the address combinationally.

Top module: `ext_irq_trigger`

## Requirements
- R1: The trigger field of pin n sits in configuration byte n/4 (offset 0 holds pins 0 to 3, offset 1 holds pins 4 to 7), at bits 2(n mod 4)+1 : 2(n mod 4). Field codes: 0 = level low, 1 = level high, 2 = rising edge, 3 = falling edge.
- R2: After reset every pin is in falling-edge mode, so both configuration bytes read 0xFF, and no strobe is raised while the pins stay low.
- R3: A write to offset 0 or 1 stores the byte, and a later read of that offset returns the stored byte.
- R4: Offsets 2 and 3 read as zero, and writes to them leave both configuration bytes unchanged.
- R5: In level-low mode the strobe is high on every cycle in which the synchronised pin is 0, and low otherwise.
- R6: In level-high mode the strobe is high on every cycle in which the synchronised pin is 1, and low otherwise.
- R7: In rising-edge mode a 0-to-1 change of the synchronised pin gives a strobe exactly one cycle long. A 1-to-0 change gives none.
- R8: In falling-edge mode a 1-to-0 change of the synchronised pin gives a strobe exactly one cycle long. A 0-to-1 change gives none.
- R9: The strobe is combinational from the second synchroniser stage. A pin change set up before clock edge A is first visible on the strobe after edge A+1, and not after edge A.
- R10: A write to a configuration byte reloads the previous-sample register of its four pins from the first synchroniser stage. An edge that reaches the second stage on the same clock edge as the write is therefore not reported for those pins. The other four pins are not affected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | NPINS (8) | Asynchronous external interrupt pins |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | AW (2) | Configuration byte offset |
| cfg_wdata | input | DW (8) | Configuration write data |
| cfg_rdata | output | DW (8) | Configuration read data for cfg_addr |
| req_set_o | output | NPINS (8) | Per-pin request-set strobe |

## Verification
Several properties are checked on every cycle. In both level modes the strobe must equal the pin as it was two cycles earlier. An edge strobe must never last two cycles when no write occurs. Any edge strobe must be explained by the pin history. Reads of the unused offsets must return zero, and writes to them must leave the mode state unchanged. Some behaviour can only be shown by the bench's scenarios. These are the mapping of each field to its pin under mixed configurations, the reset contents, the exact first cycle of a strobe, and the suppression of an edge that coincides with a configuration write.

// File: rtl/ext_irq_trigger.sv
module ext_irq_trigger #(
  parameter int NPINS = 8,
  parameter int AW    = 2,
  parameter int DW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_i,
  input  logic             cfg_we,
  input  logic [AW-1:0]    cfg_addr,
  input  logic [DW-1:0]    cfg_wdata,
  output logic [DW-1:0]    cfg_rdata,
  output logic [NPINS-1:0] req_set_o
);
  localparam int PER_BYTE = DW / 2;
  localparam int NBYTES   = NPINS / PER_BYTE;
  localparam logic [1:0] M_LOW  = 2'd0;
  localparam logic [1:0] M_HIGH = 2'd1;
  localparam logic [1:0] M_RISE = 2'd2;
  localparam logic [1:0] M_FALL = 2'd3;

  logic [DW-1:0]      cfg_q [NBYTES];
  logic [NPINS-1:0]   sync1_q, sync2_q, prev_q, reload;
  logic [2*NPINS-1:0] mode_flat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
      prev_q  <= '0;
    end else begin
      sync1_q <= pin_i;
      sync2_q <= sync1_q;
      prev_q  <= (reload & sync1_q) | (~reload & sync2_q);
    end
  end

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    logic hit;
    assign hit = cfg_we && (cfg_addr == AW'(b));
    assign reload[b*PER_BYTE +: PER_BYTE] = {PER_BYTE{hit}};

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cfg_q[b] <= {PER_BYTE{M_FALL}};
      else if (hit) cfg_q[b] <= cfg_wdata;
    end
  end

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    localparam int BI = i / PER_BYTE;
    localparam int FI = i % PER_BYTE;
    logic det;
    assign mode_flat[2*i +: 2] = cfg_q[BI][2*FI +: 2];

    always_comb begin
      case (mode_flat[2*i +: 2])
        M_LOW:   det = ~sync2_q[i];
        M_HIGH:  det = sync2_q[i];
        M_RISE:  det = sync2_q[i] & ~prev_q[i];
        default: det = ~sync2_q[i] & prev_q[i];
      endcase
    end
    assign req_set_o[i] = det;
  end

  always_comb begin
    cfg_rdata = '0;
    for (int b = 0; b < NBYTES; b++)
      if (cfg_addr == AW'(b)) cfg_rdata = cfg_q[b];
  end
endmodule

// File: rtl/ext_irq_trigger_chk.sv
module ext_irq_trigger_chk #(
  parameter int NPINS = 8,
  parameter int AW    = 2,
  parameter int DW    = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NPINS-1:0]   pin_i,
  input logic               cfg_we,
  input logic [AW-1:0]      cfg_addr,
  input logic [DW-1:0]      cfg_rdata,
  input logic [NPINS-1:0]   req_set_o,
  input logic [2*NPINS-1:0] mode_flat
);
  localparam int NBYTES = NPINS / (DW / 2);
  logic [1:0] cyc;
  logic       reserved;

  assign reserved = {1'b0, cfg_addr} >= (AW+1)'(NBYTES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cyc <= '0;
    else if (cyc != 2'd3) cyc <= cyc + 2'd1;
  end

  p_reserved_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    reserved |-> cfg_rdata == '0);

  p_reserved_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && reserved) |=> $stable(mode_flat));

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    p_low_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc == 2'd3 && mode_flat[2*i +: 2] == 2'd0) |-> req_set_o[i] == !$past(pin_i[i], 2));

    p_high_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc == 2'd3 && mode_flat[2*i +: 2] == 2'd1) |-> req_set_o[i] == $past(pin_i[i], 2));

    // Covers R7 and R8: edge strobes last a single cycle.
    p_edge_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_flat[2*i+1] && req_set_o[i] && !cfg_we) |=> !req_set_o[i]);

    p_rise_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc == 2'd3 && mode_flat[2*i +: 2] == 2'd2 && req_set_o[i])
        |-> ($past(pin_i[i], 2) && !$past(pin_i[i], 3)));

    p_fall_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc == 2'd3 && mode_flat[2*i +: 2] == 2'd3 && req_set_o[i])
        |-> (!$past(pin_i[i], 2) && $past(pin_i[i], 3)));
  end
endmodule

bind ext_irq_trigger ext_irq_trigger_chk #(.NPINS(NPINS), .AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
  .cfg_rdata(cfg_rdata), .req_set_o(req_set_o), .mode_flat(mode_flat)
);

// File: tb/ext_irq_trigger_test.sv
`timescale 1ns/1ps
module ext_irq_trigger_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pin_i = '0;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata, req_set_o;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ext_irq_trigger uut (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_set_o(req_set_o)
  );

  // {cfg byte0, cfg byte1, old pin level, new pin level, strobe first cycle, strobe later}
  localparam logic [33:0] VEC [10] = '{
    {8'h00, 8'h00, 1'b1, 1'b0, 8'hFF, 8'hFF},
    {8'h00, 8'h00, 1'b0, 1'b1, 8'h00, 8'h00},
    {8'h55, 8'h55, 1'b0, 1'b1, 8'hFF, 8'hFF},
    {8'h55, 8'h55, 1'b1, 1'b0, 8'h00, 8'h00},
    {8'hAA, 8'hAA, 1'b0, 1'b1, 8'hFF, 8'h00},
    {8'hAA, 8'hAA, 1'b1, 1'b0, 8'h00, 8'h00},
    {8'hFF, 8'hFF, 1'b1, 1'b0, 8'hFF, 8'h00},
    {8'hFF, 8'hFF, 1'b0, 1'b1, 8'h00, 8'h00},
    {8'hE4, 8'h1B, 1'b0, 1'b1, 8'h66, 8'h42},
    {8'hE4, 8'h1B, 1'b1, 1'b0, 8'h99, 8'h81}
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    cfg_addr = a;
    #1 d = cfg_rdata;
  endtask

  function automatic string tag_of(input logic [7:0] c0, input logic [7:0] c1);
    if (c0 != c1)        return "R1";
    else if (c0 == 8'h00) return "R5";
    else if (c0 == 8'h55) return "R6";
    else if (c0 == 8'hAA) return "R7";
    else                  return "R8";
  endfunction

  initial begin
    #(5.0 * 100000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();
    rd(2'd0, d); check("R2 byte0 reset", d, 8'hFF);
    rd(2'd1, d); check("R2 byte1 reset", d, 8'hFF);
    check("R2 idle strobe", req_set_o, 8'h00);

    wr(2'd0, 8'h1B); rd(2'd0, d); check("R3 byte0 readback", d, 8'h1B);
    wr(2'd1, 8'hE4); rd(2'd1, d); check("R3 byte1 readback", d, 8'hE4);
    wr(2'd2, 8'h00); wr(2'd3, 8'h00);
    rd(2'd2, d); check("R4 offset2 read", d, 8'h00);
    rd(2'd3, d); check("R4 offset3 read", d, 8'h00);
    rd(2'd0, d); check("R4 byte0 kept", d, 8'h1B);
    rd(2'd1, d); check("R4 byte1 kept", d, 8'hE4);

    for (int k = 0; k < 10; k++) begin
      logic [7:0] c0, c1, ef, eh;
      logic a, b;
      {c0, c1, a, b, ef, eh} = VEC[k];
      wr(2'd0, c0); wr(2'd1, c1);
      pin_i = {8{a}};
      repeat (4) tick();
      pin_i = {8{b}};
      tick(); tick();
      check(tag_of(c0, c1), req_set_o, ef);
      tick();
      check(tag_of(c0, c1), req_set_o, eh);
    end

    // R9: rising edge appears after the second edge, not the first
    wr(2'd0, 8'hAA); wr(2'd1, 8'hAA);
    pin_i = 8'h00;
    repeat (4) tick();
    pin_i = 8'hFF;
    tick(); check("R9 one edge", req_set_o, 8'h00);
    tick(); check("R9 two edges", req_set_o, 8'hFF);
    tick(); check("R7 pulse ends", req_set_o, 8'h00);

    // R10: write on the edge that brings the rise into stage two
    pin_i = 8'h00;
    repeat (4) tick();
    pin_i = 8'hFF;
    tick();
    wr(2'd0, 8'hAA);
    check("R10 masked low pins", req_set_o, 8'hF0);
    tick();
    check("R10 after", req_set_o, 8'h00);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule